// File: doc/BRIEF.md
# Retirement PC-Chain Consistency Monitor

This monitor sits beside a processor core's retirement trace and checks that control flow is continuous. The core may retire several instructions in one cycle across parallel retire channels, and it may report them out of order. Each channel carries a valid bit, a sequence index that the core assigns in program order starting at zero after reset, the address of the instruction and the address the core says comes next. For every pair of neighbouring indices k and k+1, the monitor requires that the address of k+1 equals the next address of k. The order in which the two records show up does not matter.

Arriving records are parked in a small window of slots keyed by the low bits of their index. A drain stage walks the window in index order from the oldest index still missing, compares each record against the link carried from its predecessor, and frees the slot. A record that cannot be placed raises a gap error. This covers an index outside the window, a duplicate, and a stale index. When a missing index holds up a non-empty window for a set number of cycles, the monitor also raises a gap error, skips the missing index and restarts the chain.

Top module: `rcm_pcchain_monitor`

## Requirements
- R1: After reset the expected index is 0, and the first record drained after reset (or after a timeout skip) is not compared against any predecessor.
- R2: When record k+1 is drained and its address differs from the next address of record k, `chain_err` is high for one cycle, in the cycle after the clock edge that sampled the completing record, with `chain_idx` = k+1. If several breaks complete in the same cycle, only the lowest of them is reported.
- R3: A pair whose later index arrives in an earlier cycle than its predecessor is checked once the predecessor arrives.
- R4: Pairs whose two records arrive in the same cycle are checked, whichever channel carries the earlier index.
- R5: A record whose index minus the expected index (modulo 2^IDXW) is WIN or more, or whose slot is already taken, is dropped. It raises `gap_err` one cycle later with `gap_idx` set to its index.
- R6: Within one cycle, channels are taken in ascending channel number. The lower channel keeps a contested slot, and `gap_idx` names the first rejected record.
- R7: When records are pending, nothing drains and the expected index stays missing for TMO consecutive cycles, `gap_err` pulses with `gap_idx` = the missing index. The expected index then advances by one, and the next drained record starts a new chain unchecked. A rejection in the same cycle takes priority for `gap_idx`.
- R8: While reset is held, `chain_err` and `gap_err` are low and the window is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_vld | input | NCH | Per-channel record valid |
| ret_idx | input | NCH*IDXW | Per-channel sequence index, channel 0 in the low bits |
| ret_pc | input | NCH*XLEN | Per-channel instruction address |
| ret_npc | input | NCH*XLEN | Per-channel next instruction address |
| chain_err | output | 1 | One-cycle pulse on a broken address link |
| chain_idx | output | IDXW | Index of the later record of the last broken pair |
| gap_err | output | 1 | One-cycle pulse on a rejected record or a timeout skip |
| gap_idx | output | IDXW | Index behind the last gap pulse |

## Verification
The hardest state to reach from the ports is the timeout skip. It needs a window that holds later records while the expected index never arrives, kept up for exactly TMO idle cycles. After the skip, the chain must restart unchecked and a late arrival of the skipped index must be rejected as stale. The stimulus parks a single record one index beyond the expected one and then idles, counting cycles until the pulse. It then confirms that the parked record drains without a compare and that its successor is compared against it. Reversed pairs are produced both across cycles, by holding back an index for a cycle, and within a cycle, by putting the higher index on channel 0.

// File: rtl/rcm_pkg.sv
// Shared defaults for the retirement PC-chain monitor.
// Assumes: WIN is a power of two of at least 2, and TMO is at least 2.
package rcm_pkg;
    localparam int unsigned RCM_NCH  = 2;
    localparam int unsigned RCM_IDXW = 8;
    localparam int unsigned RCM_XLEN = 32;
    localparam int unsigned RCM_WIN  = 4;
    localparam int unsigned RCM_TMO  = 8;
endpackage

// File: rtl/rcm_merge.sv
// Places the records of one cycle into a copy of the slot window.
// Channels are taken in ascending order, so the lower channel keeps a contested slot.
// A record outside the window, or one that lands on a taken slot, is rejected.
// Assumes: WIN is a power of two and smaller than 2**IDXW.
module rcm_merge #(
    parameter int unsigned NCH  = rcm_pkg::RCM_NCH,
    parameter int unsigned IDXW = rcm_pkg::RCM_IDXW,
    parameter int unsigned XLEN = rcm_pkg::RCM_XLEN,
    parameter int unsigned WIN  = rcm_pkg::RCM_WIN
) (
    input  logic [IDXW-1:0]           base,
    input  logic [WIN-1:0]            vld_i,
    input  logic [WIN-1:0][XLEN-1:0]  pc_i,
    input  logic [WIN-1:0][XLEN-1:0]  npc_i,
    input  logic [NCH-1:0]            ch_vld,
    input  logic [NCH-1:0][IDXW-1:0]  ch_idx,
    input  logic [NCH-1:0][XLEN-1:0]  ch_pc,
    input  logic [NCH-1:0][XLEN-1:0]  ch_npc,
    output logic [WIN-1:0]            vld_o,
    output logic [WIN-1:0][XLEN-1:0]  pc_o,
    output logic [WIN-1:0][XLEN-1:0]  npc_o,
    output logic                      rej,
    output logic [IDXW-1:0]           rej_idx
);
    localparam int unsigned SLW = $clog2(WIN);

    logic [IDXW-1:0] off;
    logic [SLW-1:0]  pos;

    // Insert each valid channel record in channel order, or flag it as rejected.
    always_comb begin
        vld_o   = vld_i;
        pc_o    = pc_i;
        npc_o   = npc_i;
        rej     = 1'b0;
        rej_idx = '0;
        off     = '0;
        pos     = '0;
        for (int c = 0; c < NCH; c++) begin
            off = ch_idx[c] - base;
            pos = ch_idx[c][SLW-1:0];
            if (ch_vld[c]) begin
                if ((off >= IDXW'(WIN)) || vld_o[pos]) begin
                    if (!rej) rej_idx = ch_idx[c];
                    rej = 1'b1;
                end else begin
                    vld_o[pos] = 1'b1;
                    pc_o[pos]  = ch_pc[c];
                    npc_o[pos] = ch_npc[c];
                end
            end
        end
    end
endmodule

// File: rtl/rcm_drain.sv
// Walks the window from the expected index upward, checks each record
// against the next address of its predecessor, and frees the slot.
// It stops at the first missing index. Only the lowest break of a cycle is reported.
// Assumes: WIN is a power of two.
module rcm_drain #(
    parameter int unsigned IDXW = rcm_pkg::RCM_IDXW,
    parameter int unsigned XLEN = rcm_pkg::RCM_XLEN,
    parameter int unsigned WIN  = rcm_pkg::RCM_WIN
) (
    input  logic [IDXW-1:0]           base_i,
    input  logic                      have_i,
    input  logic [XLEN-1:0]           link_i,
    input  logic [WIN-1:0]            vld_i,
    input  logic [WIN-1:0][XLEN-1:0]  pc_i,
    input  logic [WIN-1:0][XLEN-1:0]  npc_i,
    output logic [WIN-1:0]            vld_o,
    output logic [IDXW-1:0]           base_o,
    output logic                      have_o,
    output logic [XLEN-1:0]           link_o,
    output logic                      drained,
    output logic                      mis,
    output logic [IDXW-1:0]           mis_idx
);
    localparam int unsigned SLW = $clog2(WIN);

    logic           go;
    logic [SLW-1:0] pos;

    // In-order drain with the link compare, unrolled over the window depth.
    always_comb begin
        vld_o   = vld_i;
        base_o  = base_i;
        have_o  = have_i;
        link_o  = link_i;
        drained = 1'b0;
        mis     = 1'b0;
        mis_idx = '0;
        go      = 1'b1;
        pos     = '0;
        for (int k = 0; k < WIN; k++) begin
            pos = base_o[SLW-1:0];
            if (go && vld_o[pos]) begin
                if (have_o && (pc_i[pos] != link_o) && !mis) begin
                    mis     = 1'b1;
                    mis_idx = base_o;
                end
                have_o     = 1'b1;
                link_o     = npc_i[pos];
                vld_o[pos] = 1'b0;
                base_o     = base_o + 1'b1;
                drained    = 1'b1;
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rcm_stall.sv
// Counts cycles in which records wait behind a missing index and nothing drains.
// It raises a timeout in the cycle the count reaches TMO.
// Assumes: TMO is at least 2, and reset is synchronous active-low.
module rcm_stall #(
    parameter int unsigned TMO = rcm_pkg::RCM_TMO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic drained,
    output logic timeout
);
    localparam int unsigned CW = $clog2(TMO + 1);

    logic [CW-1:0] stall_q;

    // Timeout when the wait has already lasted TMO-1 cycles and still nothing moves.
    assign timeout = pending && !drained && (stall_q == CW'(TMO - 1));

    // Stall counter: clears on progress, on an empty window and on a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                           stall_q <= '0;
        else if (!pending || drained || timeout) stall_q <= '0;
        else                                  stall_q <= stall_q + 1'b1;
    end

    a_r7_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q <= CW'(TMO - 1));
endmodule

// File: rtl/rcm_pcchain_monitor.sv
// Retirement PC-chain monitor.
// Parks the retire records of every channel in an index-keyed window, checks
// that the address links between neighbouring indices are continuous, and
// reports breaks, rejected records and timeout skips as one-cycle pulses.
// Assumes: indices start at 0 after reset and run in program order.
module rcm_pcchain_monitor #(
    parameter int unsigned NCH  = rcm_pkg::RCM_NCH,
    parameter int unsigned IDXW = rcm_pkg::RCM_IDXW,
    parameter int unsigned XLEN = rcm_pkg::RCM_XLEN,
    parameter int unsigned WIN  = rcm_pkg::RCM_WIN,
    parameter int unsigned TMO  = rcm_pkg::RCM_TMO
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ret_vld,
    input  logic [NCH*IDXW-1:0]  ret_idx,
    input  logic [NCH*XLEN-1:0]  ret_pc,
    input  logic [NCH*XLEN-1:0]  ret_npc,
    output logic                 chain_err,
    output logic [IDXW-1:0]      chain_idx,
    output logic                 gap_err,
    output logic [IDXW-1:0]      gap_idx
);
    localparam int unsigned SLW = $clog2(WIN);

    logic [NCH-1:0][IDXW-1:0] ch_idx;
    logic [NCH-1:0][XLEN-1:0] ch_pc, ch_npc;

    logic [WIN-1:0]           slot_vld_q;
    logic [WIN-1:0][XLEN-1:0] slot_pc_q, slot_npc_q;
    logic [IDXW-1:0]          base_q;
    logic                     have_link_q;
    logic [XLEN-1:0]          link_npc_q;

    logic [WIN-1:0]           mg_vld, dr_vld;
    logic [WIN-1:0][XLEN-1:0] mg_pc, mg_npc;
    logic                     rej, dr_have, drained, mis, timeout;
    logic [IDXW-1:0]          rej_idx, dr_base, mis_idx;
    logic [XLEN-1:0]          dr_link;

    // Split the flat channel buses into per-channel fields.
    for (genvar c = 0; c < NCH; c++) begin : g_unpack
        assign ch_idx[c] = ret_idx[c*IDXW +: IDXW];
        assign ch_pc[c]  = ret_pc[c*XLEN +: XLEN];
        assign ch_npc[c] = ret_npc[c*XLEN +: XLEN];
    end

    rcm_merge #(.NCH(NCH), .IDXW(IDXW), .XLEN(XLEN), .WIN(WIN)) u_merge (
        .base(base_q), .vld_i(slot_vld_q), .pc_i(slot_pc_q), .npc_i(slot_npc_q),
        .ch_vld(ret_vld), .ch_idx(ch_idx), .ch_pc(ch_pc), .ch_npc(ch_npc),
        .vld_o(mg_vld), .pc_o(mg_pc), .npc_o(mg_npc), .rej(rej), .rej_idx(rej_idx)
    );

    rcm_drain #(.IDXW(IDXW), .XLEN(XLEN), .WIN(WIN)) u_drain (
        .base_i(base_q), .have_i(have_link_q), .link_i(link_npc_q),
        .vld_i(mg_vld), .pc_i(mg_pc), .npc_i(mg_npc),
        .vld_o(dr_vld), .base_o(dr_base), .have_o(dr_have), .link_o(dr_link),
        .drained(drained), .mis(mis), .mis_idx(mis_idx)
    );

    rcm_stall #(.TMO(TMO)) u_stall (
        .clk(clk), .rst_n(rst_n), .pending(|dr_vld), .drained(drained), .timeout(timeout)
    );

    // Window and chain state; a timeout skips the missing index and drops the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld_q  <= '0;
            base_q      <= '0;
            have_link_q <= 1'b0;
            link_npc_q  <= '0;
        end else begin
            slot_vld_q  <= dr_vld;
            base_q      <= timeout ? dr_base + 1'b1 : dr_base;
            have_link_q <= timeout ? 1'b0 : dr_have;
            link_npc_q  <= dr_link;
        end
    end

    // Slot payloads need no reset; they are guarded by slot_vld_q.
    always_ff @(posedge clk) begin
        slot_pc_q  <= mg_pc;
        slot_npc_q <= mg_npc;
    end

    // Registered error pulses and the index behind each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_err <= 1'b0;
            chain_idx <= '0;
            gap_err   <= 1'b0;
            gap_idx   <= '0;
        end else begin
            chain_err <= mis;
            if (mis) chain_idx <= mis_idx;
            gap_err   <= rej || timeout;
            if (rej)          gap_idx <= rej_idx;
            else if (timeout) gap_idx <= dr_base;
        end
    end

    // R3: the head slot can only hold a record if the last cycle skipped an index.
    a_r3_head_drained: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_q[base_q[SLW-1:0]] |-> $past(timeout));

    // R7: the chain link is dropped only by a timeout skip.
    a_r7_link_drop_on_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (!have_link_q && $past(have_link_q)) |-> $past(timeout));

    // R2: a reported break names an index that the expected index has already passed.
    a_r2_chain_idx_drained: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |-> (IDXW'(base_q - chain_idx) >= IDXW'(1)) &&
                      (IDXW'(base_q - chain_idx) <= IDXW'(WIN)));

    // R1: a break needs a predecessor, so the expected index has moved at least twice since reset.
    a_r1_no_break_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |-> $past(drained));
endmodule

// File: tb/rcm_pcchain_monitor_test.sv
// Self-checking bench for the retirement PC-chain monitor (NCH=2, WIN=4, TMO=8).
module rcm_pcchain_monitor_test;
    localparam int unsigned IDXW = 8;
    localparam int unsigned XLEN = 32;
    localparam int unsigned TMO  = 8;
    localparam int unsigned NV   = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      ret_vld = '0;
    logic [15:0]     ret_idx = '0;
    logic [63:0]     ret_pc = '0;
    logic [63:0]     ret_npc = '0;
    logic            chain_err, gap_err;
    logic [IDXW-1:0] chain_idx, gap_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rcm_pcchain_monitor uut (
        .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_idx(ret_idx),
        .ret_pc(ret_pc), .ret_npc(ret_npc), .chain_err(chain_err),
        .chain_idx(chain_idx), .gap_err(gap_err), .gap_idx(gap_idx)
    );

    // Row: ch0 {v,idx,pc,npc} ch1 {v,idx,pc,npc}, then expected {chain,cidx,gap,gidx}.
    localparam logic [99:0] VEC [NV] = '{
        {1'b1,8'd0,16'h0100,16'h0104, 1'b0,8'd0,16'h0000,16'h0000, 1'b0,8'd0, 1'b0,8'd0},   // R1 first
        {1'b1,8'd1,16'h0104,16'h0108, 1'b1,8'd2,16'h0108,16'h010C, 1'b0,8'd0, 1'b0,8'd0},   // R4 forward
        {1'b1,8'd4,16'h0110,16'h0114, 1'b1,8'd3,16'h010C,16'h0110, 1'b0,8'd0, 1'b0,8'd0},   // R4 reversed
        {1'b1,8'd6,16'h0118,16'h011C, 1'b0,8'd0,16'h0000,16'h0000, 1'b0,8'd0, 1'b0,8'd0},   // R3 park
        {1'b1,8'd5,16'h0114,16'h0118, 1'b0,8'd0,16'h0000,16'h0000, 1'b0,8'd0, 1'b0,8'd0},   // R3 fill
        {1'b1,8'd7,16'h0200,16'h0204, 1'b0,8'd0,16'h0000,16'h0000, 1'b1,8'd7, 1'b0,8'd0},   // R2 break
        {1'b1,8'd8,16'h0204,16'h0208, 1'b0,8'd0,16'h0000,16'h0000, 1'b0,8'd0, 1'b0,8'd0},   // R2 resumes
        {1'b1,8'd9,16'h0208,16'h020C, 1'b1,8'd9,16'h0000,16'h0000, 1'b0,8'd0, 1'b1,8'd9},   // R6 duplicate
        {1'b1,8'd10,16'h020C,16'h0210, 1'b1,8'd30,16'h0000,16'h0000, 1'b0,8'd0, 1'b1,8'd30}, // R5 far, R6 ch0 kept
        {1'b1,8'd12,16'h0300,16'h0304, 1'b1,8'd11,16'h0210,16'h02FF, 1'b1,8'd12, 1'b0,8'd0}, // R4 reversed break
        {1'b0,8'd0,16'h0000,16'h0000, 1'b0,8'd0,16'h0000,16'h0000, 1'b0,8'd0, 1'b0,8'd0}    // idle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v0, input logic [7:0] i0, input logic [31:0] p0, input logic [31:0] n0,
                         input logic v1, input logic [7:0] i1, input logic [31:0] p1, input logic [31:0] n1);
        ret_vld = {v1, v0};
        ret_idx = {i1, i0};
        ret_pc  = {p1, p0};
        ret_npc = {n1, n0};
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: held reset keeps both pulses low.
        repeat (3) @(negedge clk);
        chk("R8 chain_err in reset", 32'(chain_err), 0);
        chk("R8 gap_err in reset", 32'(gap_err), 0);
        rst_n = 1'b1;

        for (int r = 0; r < NV; r++) begin
            drive(VEC[r][99], VEC[r][98:91], 32'(VEC[r][90:75]), 32'(VEC[r][74:59]),
                  VEC[r][58], VEC[r][57:50], 32'(VEC[r][49:34]), 32'(VEC[r][33:18]));
            step();
            chk($sformatf("R2 chain_err row %0d", r), 32'(chain_err), 32'(VEC[r][17]));
            if (VEC[r][17]) chk($sformatf("R2 chain_idx row %0d", r), 32'(chain_idx), 32'(VEC[r][16:9]));
            chk($sformatf("R5 gap_err row %0d", r), 32'(gap_err), 32'(VEC[r][8]));
            if (VEC[r][8]) chk($sformatf("R5 gap_idx row %0d", r), 32'(gap_idx), 32'(VEC[r][7:0]));
        end

        // R7: index 13 never comes; index 14 waits, and the timeout fires after TMO cycles.
        drive(1, 8'd14, 32'h999, 32'h400, 0, 0, 0, 0);
        step();
        chk("R7 no early timeout", 32'(gap_err), 0);
        for (int k = 1; k < TMO - 1; k++) begin
            step();
            chk("R7 no early timeout", 32'(gap_err), 0);
        end
        step();
        chk("R7 timeout pulse", 32'(gap_err), 1);
        chk("R7 timeout names missing index", 32'(gap_idx), 13);
        step();
        chk("R7 record after skip unchecked", 32'(chain_err), 0);
        drive(1, 8'd15, 32'h500, 32'h504, 0, 0, 0, 0);
        step();
        chk("R7 chain restarts from skipped record", 32'(chain_err), 1);
        chk("R7 chain restart index", 32'(chain_idx), 15);
        drive(1, 8'd13, 32'h0, 32'h0, 0, 0, 0, 0);
        step();
        chk("R5 stale index rejected", 32'(gap_err), 1);
        chk("R5 stale index value", 32'(gap_idx), 13);

        // R5: window limit; expected index 16, so 17..19 fit and 20 does not.
        drive(1, 8'd17, 32'h0, 32'h0, 1, 8'd18, 32'h0, 32'h0);
        step();
        chk("R5 in-window park", 32'(gap_err), 0);
        drive(1, 8'd19, 32'h0, 32'h0, 1, 8'd20, 32'h0, 32'h0);
        step();
        chk("R5 window edge rejected", 32'(gap_err), 1);
        chk("R5 window edge index", 32'(gap_idx), 20);

        // R8/R1: reset empties the window and the next chain starts at index 0 unchecked.
        rst_n = 1'b0;
        step();
        step();
        chk("R8 chain_err after reset", 32'(chain_err), 0);
        chk("R8 gap_err after reset", 32'(gap_err), 0);
        rst_n = 1'b1;
        drive(1, 8'd0, 32'h777, 32'h77B, 0, 0, 0, 0);
        step();
        chk("R1 first after reset unchecked", 32'(chain_err), 0);
        chk("R1 index 0 accepted", 32'(gap_err), 0);
        drive(1, 8'd1, 32'h77B, 32'h77F, 0, 0, 0, 0);
        step();
        chk("R2 good link", 32'(chain_err), 0);
        drive(0, 0, 0, 0, 1, 8'd2, 32'h0, 32'h4);
        step();
        chk("R2 break on channel 1", 32'(chain_err), 1);
        chk("R2 break index", 32'(chain_idx), 2);
        step();
        chk("R2 pulse lasts one cycle", 32'(chain_err), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule